// File: doc/BRIEF.md
# Ethernet Flow-Control Pause Frame Transmitter

This block produces one full-duplex flow-control (PAUSE) frame each time software asks for one. Software writes a 32-bit control word that carries a 16-bit pause quantum, a pass-through flag, a flow-control enable and a start bit. The start bit stays set for as long as the frame is being sent, and the block clears it itself after the last byte has been accepted. Software can therefore poll the same word to find out when the transmitter is free again.

The frame is sent one byte per accepted transfer on a byte stream with valid/ready flow control. The stream runs from the preamble through the checksum, and a last marker flags the final byte. The frame has a fixed layout. It opens with the preamble and the start delimiter. Next come the reserved multicast destination, a station address taken from a configuration input, the MAC-control type and the pause opcode, then the register's pause value and zero padding up to the minimum frame size. A CRC-32 over the payload region closes the frame. The checksum is computed on the fly as the bytes leave.

Top module: `pause_tx`

## Requirements
- R1: After reset, `reg_rd_data` reads 0 and both `tx_valid` and `tx_last` are 0.
- R2: A write made while the busy bit (bit 0) is 0 stores the pause quantum from bits 31:16, the pass flag from bit 2 and the enable from bit 1. These fields read back at the same positions, and bits 15:3 read as 0.
- R3: A write with bit 0 = 1 and bit 1 = 1, made while `full_duplex` is 1 and busy is 0, sets busy. `tx_valid` is 1 from the next cycle on and equals the busy bit for as long as the frame lasts.
- R4: A start write made while `full_duplex` is 0, or with bit 1 = 0, leaves busy at 0 and produces no output byte. The other fields of that write are still stored.
- R5: While busy is 1, every register write is ignored. The stored fields do not change, and the frame in progress keeps the pause value it started with.
- R6: The frame is 72 bytes long. In order, it carries 7 bytes of 0x55, one byte 0xD5, then 01 80 C2 00 00 01. Next comes `src_mac` with bits 47:40 first, then 88 08 00 01. After that come the pause quantum (bits 31:16 of the register), high byte first, and then 42 bytes of 0x00.
- R7: Bytes 69 to 72 are the CRC-32 of bytes 9 to 68. The CRC uses the reflected polynomial 0xEDB88320 with an all-ones start value. It is sent complemented, least significant byte first.
- R8: The byte index advances only on a cycle with `tx_valid` and `tx_ready` both 1. While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_last` hold their values.
- R9: `tx_last` is 1 only with the 72nd byte of a frame.
- R10: Busy returns to 0 in the cycle after the 72nd byte is accepted. A write that arrives in that same acceptance cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write value |
| reg_rd_data | output | 32 | Control register contents |
| full_duplex | input | 1 | Link is in full-duplex mode |
| src_mac | input | 48 | Station address placed in the source field |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | `tx_data` holds a frame byte |
| tx_ready | input | 1 | Sink accepts the byte this cycle |
| tx_last | output | 1 | Marks the final byte of the frame |

## Verification
Two events can fall in the same cycle: the end of a frame, when busy clears, and a new software write that tries to start another frame. The bench provokes this by raising a start write in exactly the cycle in which the 72nd byte is accepted. It then expects busy to read 0 on the next cycle and no new `tx_valid`, so the end of the frame takes priority and the write is dropped. The bench also stalls `tx_ready` with several different patterns, to show that the checksum and the byte order do not depend on how often the sink pauses.

// File: rtl/pause_tx_pkg.sv
// Package: frame geometry, field constants and the CRC byte update shared by
// the pause transmitter. Assumes the standard minimum-size control frame.
package pause_tx_pkg;

    localparam int PREAMBLE_LEN = 7;
    localparam int ADDR_LEN     = 6;
    localparam int PAD_LEN      = 42;
    localparam int CRC_LEN      = 4;

    // byte offsets of each field inside the frame
    localparam int OFS_SFD   = PREAMBLE_LEN;
    localparam int OFS_DST   = OFS_SFD + 1;
    localparam int OFS_SRC   = OFS_DST + ADDR_LEN;
    localparam int OFS_TYPE  = OFS_SRC + ADDR_LEN;
    localparam int OFS_OPC   = OFS_TYPE + 2;
    localparam int OFS_QUANT = OFS_OPC + 2;
    localparam int OFS_PAD   = OFS_QUANT + 2;
    localparam int OFS_CRC   = OFS_PAD + PAD_LEN;
    localparam int FRAME_LEN = OFS_CRC + CRC_LEN;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [47:0] CTRL_DST      = 48'h0180C2000001;
    localparam logic [15:0] CTRL_TYPE     = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;
    localparam logic [31:0] CRC_POLY      = 32'hEDB88320;

    // Fold one byte into a reflected CRC-32 remainder, one bit per step.
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc ^ {24'd0, data};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pause_tx_csr.sv
// Control register: holds the pause quantum, pass flag, enable and busy.
// Assumes a write takes effect on the clock edge at which it is presented.
// While busy is set, writes are dropped; done has priority over a write.
module pause_tx_csr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        full_duplex,
    input  logic        done,
    output logic        start,
    output logic        busy,
    output logic [15:0] quantum,
    output logic [31:0] rd_data
);
    logic pass_q;
    logic enable_q;

    // Decide whether this write launches a frame.
    always_comb begin
        start = wr_en && !busy && wr_data[0] && wr_data[1] && full_duplex;
    end

    // Register update: done clears busy, an idle write loads the fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            pass_q   <= 1'b0;
            enable_q <= 1'b0;
            quantum  <= '0;
        end else if (busy) begin
            if (done) busy <= 1'b0;
        end else if (wr_en) begin
            quantum  <= wr_data[31:16];
            pass_q   <= wr_data[2];
            enable_q <= wr_data[1];
            busy     <= start;
        end
    end

    // Read view in the register's own bit layout.
    always_comb begin
        rd_data = {quantum, 13'd0, pass_q, enable_q, busy};
    end
endmodule

// File: rtl/pause_tx_crc.sv
// Running CRC-32 over the payload bytes. Assumes init and en never overlap.
// Exposes the raw remainder; the caller complements it on output.
module pause_tx_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc
);
    import pause_tx_pkg::*;

    // Hold the remainder: preset on init, fold a byte on en.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= '1;
        else if (init) crc <= '1;
        else if (en)   crc <= crc32_byte(crc, data);
    end
endmodule

// File: rtl/pause_tx_seq.sv
// Byte sequencer: walks the frame index while busy and selects each byte.
// Assumes busy stays set until done and that src_mac is stable per frame.
module pause_tx_seq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy,
    input  logic        ready,
    input  logic [15:0] quantum,
    input  logic [47:0] src_mac,
    input  logic [31:0] crc,
    output logic [7:0]  data,
    output logic        last,
    output logic        crc_en,
    output logic        done
);
    import pause_tx_pkg::*;

    localparam int LAST_IDX = FRAME_LEN - 1;

    logic [IDX_W-1:0] idx;
    logic             adv;
    int               pos;

    // Handshake and field boundaries.
    always_comb begin
        pos    = int'(idx);
        adv    = busy && ready;
        last   = busy && (pos == LAST_IDX);
        done   = adv && (pos == LAST_IDX);
        crc_en = adv && (pos >= OFS_DST) && (pos < OFS_CRC);
    end

    // Frame index: advance per accepted byte, wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (done) idx <= '0;
        else if (adv)  idx <= idx + 1'b1;
    end

    // Byte selection by field.
    always_comb begin
        if (pos < OFS_SFD)        data = PREAMBLE_BYTE;
        else if (pos < OFS_DST)   data = SFD_BYTE;
        else if (pos < OFS_SRC)   data = CTRL_DST[8*(OFS_SRC-1-pos) +: 8];
        else if (pos < OFS_TYPE)  data = src_mac[8*(OFS_TYPE-1-pos) +: 8];
        else if (pos < OFS_OPC)   data = CTRL_TYPE[8*(OFS_OPC-1-pos) +: 8];
        else if (pos < OFS_QUANT) data = PAUSE_OPCODE[8*(OFS_QUANT-1-pos) +: 8];
        else if (pos < OFS_PAD)   data = quantum[8*(OFS_PAD-1-pos) +: 8];
        else if (pos < OFS_CRC)   data = 8'h00;
        else                      data = ~crc[8*(pos-OFS_CRC) +: 8];
    end
endmodule

// File: rtl/pause_tx.sv
// Top: pause frame transmitter. Register, sequencer and CRC joined here.
// Assumes the sink obeys valid/ready and the link mode is quasi-static.
module pause_tx (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        full_duplex,
    input  logic [47:0] src_mac,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        tx_last
);
    logic        start;
    logic        busy;
    logic        done;
    logic        crc_en;
    logic [15:0] quantum;
    logic [31:0] crc;

    pause_tx_csr u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
        .full_duplex(full_duplex), .done(done), .start(start), .busy(busy),
        .quantum(quantum), .rd_data(reg_rd_data)
    );

    pause_tx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .busy(busy), .ready(tx_ready),
        .quantum(quantum), .src_mac(src_mac), .crc(crc), .data(tx_data),
        .last(tx_last), .crc_en(crc_en), .done(done)
    );

    pause_tx_crc u_crc (
        .clk(clk), .rst_n(rst_n), .init(start), .en(crc_en),
        .data(tx_data), .crc(crc)
    );

    // Output valid mirrors the busy bit.
    always_comb begin
        tx_valid = busy;
    end
endmodule

// File: rtl/pause_tx_chk.sv
// Checker: port-level protocol properties of the pause transmitter.
module pause_tx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_rd_data,
    input logic        full_duplex,
    input logic [7:0]  tx_data,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_last
);
    AST_VALID_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid == reg_rd_data[0]); // R3
    AST_NO_START_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd_data[0] && !full_duplex) |=> !reg_rd_data[0]); // R4
    AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[0] && !(tx_ready && tx_last)) |=> $stable(reg_rd_data)); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> ($stable(tx_data) && $stable(tx_last))); // R8
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R9
    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> (!reg_rd_data[0] && !tx_valid)); // R10
endmodule

bind pause_tx pause_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_data(reg_rd_data),
    .full_duplex(full_duplex), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last)
);

// File: tb/pause_tx_tb.sv
module pause_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        full_duplex = 1'b1;
    logic [47:0] src_mac = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        tx_last;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_b [72];
    logic [7:0] got_b [72];
    logic       got_l [72];
    int         nbytes;
    int         stall_bad;

    // pause quantum, ready pattern, address seed
    localparam logic [39:0] VEC [4] = '{
        {16'h0000, 8'hFF, 16'h0011},
        {16'hFFFF, 8'hAA, 16'h2233},
        {16'h1234, 8'h5B, 16'h4455},
        {16'hA55A, 8'h81, 16'h6677}
    };

    always #2.5 clk = ~clk;

    pause_tx u_dut (.*);

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int from, input int upto);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int i = from; i < upto; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (r[0] ^ exp_b[i][b]) r = (r >> 1) ^ 32'hEDB88320;
                else                    r = r >> 1;
            end
        end
        return r;
    endfunction

    task automatic build_expected(input logic [15:0] q, input logic [47:0] mac);
        logic [31:0] c;
        for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
        exp_b[7] = 8'hD5;
        exp_b[8] = 8'h01; exp_b[9] = 8'h80; exp_b[10] = 8'hC2;
        exp_b[11] = 8'h00; exp_b[12] = 8'h00; exp_b[13] = 8'h01;
        for (int i = 0; i < 6; i++) exp_b[14+i] = mac[47-8*i -: 8];
        exp_b[20] = 8'h88; exp_b[21] = 8'h08; exp_b[22] = 8'h00; exp_b[23] = 8'h01;
        exp_b[24] = q[15:8]; exp_b[25] = q[7:0];
        for (int i = 26; i < 68; i++) exp_b[i] = 8'h00;
        c = ~ref_crc(8, 68);
        for (int i = 0; i < 4; i++) exp_b[68+i] = c[8*i +: 8];
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Collect one frame; optionally raise a start write with the final byte.
    task automatic capture(input logic [7:0] mask, input bit collide, input logic [31:0] cw);
        int cyc = 0;
        logic [7:0] pd = '0;
        logic pl = 1'b0, pstall = 1'b0;
        nbytes = 0; stall_bad = 0;
        while (nbytes < 72 && cyc < 3000) begin
            @(negedge clk);
            reg_wr_en = 1'b0;
            if (pstall && (tx_data !== pd || tx_last !== pl)) stall_bad++;
            tx_ready = mask[cyc % 8];
            #0.5;
            if (tx_valid && tx_ready) begin
                got_b[nbytes] = tx_data;
                got_l[nbytes] = tx_last;
                if (collide && nbytes == 71) begin
                    reg_wr_en = 1'b1; reg_wr_data = cw;
                end
                nbytes++;
            end
            pstall = tx_valid && !tx_ready;
            pd = tx_data; pl = tx_last;
            cyc++;
        end
        @(negedge clk);
        reg_wr_en = 1'b0;
        tx_ready = 1'b0;
    endtask

    task automatic judge_frame(input string tag);
        int bad_hdr = 0, bad_crc = 0, bad_last = 0;
        check({tag, " R6 byte count"}, nbytes, 72);
        for (int i = 0; i < 68; i++) if (got_b[i] !== exp_b[i]) bad_hdr++;
        for (int i = 68; i < 72; i++) if (got_b[i] !== exp_b[i]) bad_crc++;
        for (int i = 0; i < 72; i++) if (got_l[i] !== (i == 71)) bad_last++;
        check({tag, " R6 field mismatches"}, bad_hdr, 0);
        check({tag, " R7 crc mismatches"}, bad_crc, 0);
        check({tag, " R9 last misplaced"}, bad_last, 0);
        check({tag, " R8 stall changes"}, stall_bad, 0);
    endtask

    initial begin
        logic [15:0] q;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reg", reg_rd_data, 32'h0);
        check("R1 valid/last", {tx_valid, tx_last}, 2'b00);
        rst_n = 1'b1;

        // Vector table walk: R2 R3 R6 R7 R8 R9 R10
        for (int v = 0; v < 4; v++) begin
            q = VEC[v][39:24];
            src_mac = {VEC[v][15:0], ~VEC[v][15:0], q};
            build_expected(q, src_mac);
            w = {q, 13'd0, v[0], 2'b11};
            reg_write(w);
            check("R3 busy and valid after start", {reg_rd_data[0], tx_valid}, 2'b11);
            check("R2 fields readback", reg_rd_data, w);
            capture(VEC[v][23:16], 1'b0, 32'h0);
            judge_frame("vec");
            check("R10 busy cleared", {reg_rd_data[0], tx_valid}, 2'b00);
        end

        // R4 half duplex start ignored, fields stored
        full_duplex = 1'b0;
        reg_write(32'hBEEF0007);
        repeat (3) @(negedge clk);
        check("R4 half duplex no start", {reg_rd_data[0], tx_valid}, 2'b00);
        check("R4 fields kept", reg_rd_data, 32'hBEEF0006);
        full_duplex = 1'b1;

        // R4 enable clear ignored
        reg_write(32'h12340001);
        repeat (3) @(negedge clk);
        check("R4 enable off no start", {reg_rd_data[0], tx_valid}, 2'b00);
        check("R4 fields kept", reg_rd_data, 32'h12340000);

        // R5 write while busy ignored
        src_mac = 48'h020000000001;
        build_expected(16'h0102, src_mac);
        reg_write(32'h01020003);
        reg_write(32'hFFFF0004);
        check("R5 register frozen", reg_rd_data, 32'h01020003);
        capture(8'hFF, 1'b0, 32'h0);
        judge_frame("busy-write");

        // R10 start write in final acceptance cycle is dropped
        build_expected(16'h7777, src_mac);
        reg_write(32'h77770003);
        capture(8'h6D, 1'b1, 32'h99990003);
        judge_frame("collide");
        repeat (4) @(negedge clk);
        check("R10 collided write dropped", {reg_rd_data[0], tx_valid}, 2'b00);
        check("R10 register after collision", reg_rd_data, 32'h77770002);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule